// File: doc/BRIEF.md
# Event-Driven Saturating Neuron Sequencer

This block is a clocked neuron core driven entirely by incoming spike events. Each event carries a source id, a routing tag and a timestamp. Events enter a two-slot queue through a valid/ready port. While no event is queued the core does nothing. When an event is taken from the queue, the core runs a short routine of micro-ops, one per clock. The routine starts at the base address that is configured for the event's tag. The micro-ops operate on a file of eight signed 4-bit registers, and every arithmetic result saturates.

The micro-op store and the synaptic weight store sit outside the block. The core addresses the micro-op store and reads the word back in the same cycle. It reads and writes the weight store at the index of the most recently received source id. A compare-and-fire micro-op produces an 8-bit result beat. The beat is held on a valid/ready output until the consumer accepts it. Three single-cycle pulses act on the core: one reloads the register file from an initial image, one drops the held beat, and one empties the queue.

Top module: `spk_ucode_neuron`

## Requirements
- R1: An event is accepted at a rising edge where `ev_valid` and `ev_ready` are both high. The queue holds two events. `ev_ready` is low while two events are queued, except in a cycle where the core takes one out, so that a push and a pop can share that cycle. An event offered while `ev_ready` is low is not taken and has no effect.
- R2: While no routine runs and the queue is not empty, the core takes the oldest event in one cycle. It then runs `cfg_len` micro-ops starting at address `cfg_base[4*tag+3:4*tag]`. If `cfg_len` is 0, the event is discarded without running anything. After a hard reset the queue is empty, no beat is held and `ev_ready` is high.
- R3: A running routine executes exactly one micro-op per cycle. `uc_addr` rises by one each cycle and wraps modulo 16.
- R4: A micro-op word is laid out as opcode[15:12], destination register[11:9], source register[8:6] and immediate[5:0]. The opcodes are 0 NOP, 1 RECV, 2 LDW, 3 ADD, 4 ADDI, 5 LEAK, 6 TDEC, 7 REFR, 8 FIRE, 9 STDP and 10 MOV. Opcodes 11 to 15 change nothing.
- R5: Registers are indexed as 0 V (membrane), 1 I, 2 TH, 3 R (refractory), 4 T0, 5 T1, 6 W and 7 AUX. ADD computes dst+src. ADDI computes dst plus the signed 6-bit immediate. Both results are clamped to -8..+7. MOV copies src into dst.
- R6: RECV copies the current event's source id, tag and timestamp into the last-id, last-tag and last-time registers. LDW loads dst from the weight store at the index given by last-id (`wt_addr`).
- R7: LEAK sets dst to dst >>> imm[1:0]. TDEC, when dst > 0, subtracts 2^imm[1:0] from dst and stops at 0. REFR, when R > 0, decrements R and sets V to V >>> imm[1:0]. When R <= 0, REFR does nothing.
- R8: FIRE spikes when V >= TH and R <= 0. A spike clears V and loads R with imm[2:0]. Every FIRE produces a beat: bit 7 is 1, bits 6:5 hold last-tag, bits 4:1 hold last-id, and bit 0 is 1 if a spike occurred.
- R9: STDP writes to the weight store at last-id. The value written is the sign of sat(dst+src), so it is always -1, 0 or +1.
- R10: A beat stays on `out_data` with `out_valid` high until it is accepted while `out_ready` is high. If a FIRE happens while an earlier beat is held and not being accepted, the new beat is lost. `clr_out` drops the held beat and takes priority over a FIRE in the same cycle.
- R11: `soft_rst` loads register k from `cfg_init[4k+3:4k]`. It also clears last-id, last-tag, last-time and the spike flag, and it aborts any running routine. The queue and the held beat are left unchanged.
- R12: `flush` empties the queue. In the same cycle it drops any offered event and blocks dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Event offered |
| ev_ready | output | 1 | Queue can take the event |
| ev_sid | input | 4 | Event source id |
| ev_tag | input | 2 | Event tag, selects the routine |
| ev_time | input | 6 | Event timestamp |
| uc_addr | output | 4 | Micro-op store address |
| uc_data | input | 16 | Micro-op word at `uc_addr` |
| wt_addr | output | 4 | Weight store index (last-id) |
| wt_rdata | input | 4 | Weight at `wt_addr` |
| wt_we | output | 1 | Weight write strobe |
| wt_wdata | output | 4 | Ternary weight to write |
| cfg_base | input | 16 | Routine base address per tag, 4 bits each |
| cfg_len | input | 5 | Routine length in micro-ops (0..16) |
| cfg_init | input | 32 | Initial register image, 4 bits per register |
| soft_rst | input | 1 | Reload the registers and clear the last-event fields |
| clr_out | input | 1 | Drop the held beat |
| flush | input | 1 | Empty the event queue |
| out_valid | output | 1 | Beat held |
| out_ready | input | 1 | Consumer accepts the beat |
| out_data | output | 8 | Result beat |

## Verification
Two queue operations can land on the same edge: a push at the input and the core's dequeue. The bench sets this up by filling the queue while a long routine runs and then keeping a fourth event offered. `ev_ready` has to stay low until the routine ends, and it must rise in the dispatch cycle itself. The bench judges the outcome by the beats: four beats must appear, carrying the source ids in push order. A second pairing is also checked. The bench lets a FIRE fall while a beat is held and not accepted. It then verifies that the earlier beat is the one that stays on `out_data`.

// File: rtl/spk_pkg.sv
package spk_pkg;
  localparam int SID_W = 4;
  localparam int TAG_W = 2;
  localparam int TS_W  = 6;
  localparam int RW    = 4;
  localparam int NREG  = 8;
  localparam int UOP_W = 16;
  localparam int NTAG  = 1 << TAG_W;
  localparam int RIX_W = $clog2(NREG);
  localparam int OUT_W = 2 + TAG_W + SID_W;

  localparam int IX_V  = 0;
  localparam int IX_TH = 2;
  localparam int IX_R  = 3;

  typedef logic signed [RW-1:0] nval_t;

  typedef struct packed {
    logic [SID_W-1:0] sid;
    logic [TAG_W-1:0] tag;
    logic [TS_W-1:0]  ts;
  } spk_ev_t;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_RECV = 4'd1,
    OP_LDW  = 4'd2,
    OP_ADD  = 4'd3,
    OP_ADDI = 4'd4,
    OP_LEAK = 4'd5,
    OP_TDEC = 4'd6,
    OP_REFR = 4'd7,
    OP_FIRE = 4'd8,
    OP_STDP = 4'd9,
    OP_MOV  = 4'd10
  } uop_e;

  function automatic logic signed [6:0] ext7(input nval_t x);
    return {{3{x[RW-1]}}, x};
  endfunction

  function automatic nval_t sat4(input logic signed [6:0] x);
    if (x > 7'sd7)       return 4'sd7;
    else if (x < -7'sd8) return -4'sd8;
    else                 return x[RW-1:0];
  endfunction

  function automatic nval_t tern(input nval_t x);
    if (x > 4'sd0)      return 4'sd1;
    else if (x < 4'sd0) return -4'sd1;
    else                return 4'sd0;
  endfunction
endpackage

// File: rtl/spk_evq.sv
module spk_evq
  import spk_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    flush,
  input  logic    in_valid,
  output logic    in_ready,
  input  spk_ev_t in_ev,
  input  logic    pop,
  output spk_ev_t out_ev,
  output logic    nonempty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  spk_ev_t        slot_q [DEPTH];
  logic [PW-1:0]  wp_q, rp_q;
  logic [CW-1:0]  cnt_q;
  logic           full, push;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt_q == CW'(DEPTH));
  assign nonempty = (cnt_q != '0);
  assign in_ready = !full || pop;
  assign push     = in_valid && in_ready && !flush;
  assign out_ev   = slot_q[rp_q];

  always_ff @(posedge clk) begin
    if (push) slot_q[wp_q] <= in_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= nxt(wp_q);
      if (pop)  rp_q <= nxt(rp_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop && !flush) |=> full); // R1
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !nonempty); // R12
endmodule

// File: rtl/spk_exec.sv
module spk_exec
  import spk_pkg::*;
(
  input  logic                     active,
  input  logic [UOP_W-1:0]         uop,
  input  logic [NREG-1:0][RW-1:0]  rf_q,
  input  logic [RW-1:0]            wt_rdata,
  output logic [NREG-1:0][RW-1:0]  rf_d,
  output logic                     recv,
  output logic                     emit,
  output logic                     spike,
  output logic                     wt_we,
  output logic [RW-1:0]            wt_wdata
);
  uop_e              opc;
  logic [RIX_W-1:0]  rd, rs;
  logic [5:0]        imm;
  logic [1:0]        k;
  nval_t             a, b, vv, th, rr;
  logic signed [6:0] acc;

  assign opc = uop_e'(uop[15:12]);
  assign rd  = uop[11:9];
  assign rs  = uop[8:6];
  assign imm = uop[5:0];
  assign k   = imm[1:0];
  assign a   = rf_q[rd];
  assign b   = rf_q[rs];
  assign vv  = rf_q[IX_V];
  assign th  = rf_q[IX_TH];
  assign rr  = rf_q[IX_R];

  always_comb begin
    rf_d     = rf_q;
    recv     = 1'b0;
    emit     = 1'b0;
    spike    = 1'b0;
    wt_we    = 1'b0;
    wt_wdata = '0;
    acc      = '0;
    if (active) begin
      case (opc)
        OP_RECV: recv = 1'b1;
        OP_LDW:  rf_d[rd] = wt_rdata;
        OP_ADD:  rf_d[rd] = sat4(ext7(a) + ext7(b));
        OP_ADDI: rf_d[rd] = sat4(ext7(a) + {imm[5], imm});
        OP_LEAK: rf_d[rd] = a >>> k;
        OP_TDEC: begin
          if (a > 4'sd0) begin
            acc      = ext7(a) - (7'sd1 <<< k);
            rf_d[rd] = (acc < 7'sd0) ? '0 : acc[RW-1:0];
          end
        end
        OP_REFR: begin
          if (rr > 4'sd0) begin
            rf_d[IX_R] = rr - 4'sd1;
            rf_d[IX_V] = vv >>> k;
          end
        end
        OP_FIRE: begin
          emit  = 1'b1;
          spike = (vv >= th) && !(rr > 4'sd0);
          if (spike) begin
            rf_d[IX_V] = '0;
            rf_d[IX_R] = {1'b0, imm[2:0]};
          end
        end
        OP_STDP: begin
          wt_we    = 1'b1;
          wt_wdata = tern(sat4(ext7(a) + ext7(b)));
        end
        OP_MOV:  rf_d[rd] = b;
        default: ;
      endcase
    end
  end

  always_comb begin
    if (wt_we) AST_STDP_TERNARY: assert (tern(nval_t'(wt_wdata)) == nval_t'(wt_wdata)); // R9
  end
endmodule

// File: rtl/spk_ucode_neuron.sv
module spk_ucode_neuron
  import spk_pkg::*;
#(
  parameter int QDEPTH = 2,
  parameter int UC_AW  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_valid,
  output logic                  ev_ready,
  input  logic [SID_W-1:0]      ev_sid,
  input  logic [TAG_W-1:0]      ev_tag,
  input  logic [TS_W-1:0]       ev_time,
  output logic [UC_AW-1:0]      uc_addr,
  input  logic [UOP_W-1:0]      uc_data,
  output logic [SID_W-1:0]      wt_addr,
  input  logic [RW-1:0]         wt_rdata,
  output logic                  wt_we,
  output logic [RW-1:0]         wt_wdata,
  input  logic [NTAG*UC_AW-1:0] cfg_base,
  input  logic [UC_AW:0]        cfg_len,
  input  logic [NREG*RW-1:0]    cfg_init,
  input  logic                  soft_rst,
  input  logic                  clr_out,
  input  logic                  flush,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [OUT_W-1:0]      out_data
);
  localparam int LEN_W = UC_AW + 1;

  typedef enum logic {S_IDLE, S_RUN} st_e;

  spk_ev_t                  in_ev, q_ev, cur_q;
  logic                     q_nonempty, pop, active;
  st_e                      st_q;
  logic [UC_AW-1:0]         pc_q;
  logic [LEN_W-1:0]         left_q;
  logic [NREG-1:0][RW-1:0]  rf_q, rf_d;
  logic [SID_W-1:0]         last_sid_q;
  logic [TAG_W-1:0]         last_tag_q;
  logic [TS_W-1:0]          last_time_q;
  logic                     spike_flag_q;
  logic                     recv, emit, spike;

  assign in_ev   = '{sid: ev_sid, tag: ev_tag, ts: ev_time};
  assign pop     = (st_q == S_IDLE) && q_nonempty && !flush && !soft_rst;
  assign active  = (st_q == S_RUN) && !soft_rst;
  assign uc_addr = pc_q;
  assign wt_addr = last_sid_q;

  spk_evq #(.DEPTH(QDEPTH)) i_evq (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .in_valid (ev_valid),
    .in_ready (ev_ready),
    .in_ev    (in_ev),
    .pop      (pop),
    .out_ev   (q_ev),
    .nonempty (q_nonempty)
  );

  spk_exec i_exec (
    .active   (active),
    .uop      (uc_data),
    .rf_q     (rf_q),
    .wt_rdata (wt_rdata),
    .rf_d     (rf_d),
    .recv     (recv),
    .emit     (emit),
    .spike    (spike),
    .wt_we    (wt_we),
    .wt_wdata (wt_wdata)
  );

  // dispatch and micro-op sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      pc_q   <= '0;
      left_q <= '0;
      cur_q  <= '0;
    end else if (soft_rst) begin
      st_q <= S_IDLE;
    end else if (st_q == S_IDLE) begin
      if (pop && cfg_len != '0) begin
        cur_q  <= q_ev;
        pc_q   <= cfg_base[q_ev.tag*UC_AW +: UC_AW];
        left_q <= cfg_len;
        st_q   <= S_RUN;
      end
    end else begin
      pc_q   <= pc_q + 1'b1;
      left_q <= left_q - 1'b1;
      if (left_q == LEN_W'(1)) st_q <= S_IDLE;
    end
  end

  // register file and last-event fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rf_q         <= '0;
      last_sid_q   <= '0;
      last_tag_q   <= '0;
      last_time_q  <= '0;
      spike_flag_q <= 1'b0;
    end else if (soft_rst) begin
      rf_q         <= cfg_init;
      last_sid_q   <= '0;
      last_tag_q   <= '0;
      last_time_q  <= '0;
      spike_flag_q <= 1'b0;
    end else begin
      rf_q <= rf_d;
      if (recv) begin
        last_sid_q  <= cur_q.sid;
        last_tag_q  <= cur_q.tag;
        last_time_q <= cur_q.ts;
      end
      if (emit) spike_flag_q <= spike;
    end
  end

  // held result beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (clr_out) begin
      out_valid <= 1'b0;
    end else if (emit && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_data  <= {1'b1, last_tag_q, last_sid_q, spike};
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_ONE_UOP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_RUN && left_q > LEN_W'(1) && !soft_rst) |=> (uc_addr == UC_AW'($past(uc_addr) + 1'b1))); // R3
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clr_out) |=> (out_valid && $stable(out_data))); // R10
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_out |=> !out_valid); // R10
  AST_BEAT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data[OUT_W-1]); // R8
  AST_FLAG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !soft_rst) |=> (spike_flag_q == $past(spike))); // R8
  AST_RECV_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    (recv && !soft_rst) |=> (last_time_q == $past(cur_q.ts))); // R6
  AST_SOFT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rf_q == $past(cfg_init) && last_sid_q == '0 && !spike_flag_q)); // R11
endmodule

// File: tb/test_spk_ucode_neuron.sv
`timescale 1ns/1ps
module test_spk_ucode_neuron;
  localparam logic [3:0] NOP = 0, RECV = 1, LDW = 2, ADD = 3, ADDI = 4, LEAK = 5,
                         TDEC = 6, REFR = 7, FIRE = 8, STDP = 9, MOV = 10;
  localparam logic [2:0] RV = 0, RI = 1, RT0 = 4, RW_ = 6, RAUX = 7;

  logic        clk = 0, rst_n = 0;
  logic        ev_valid = 0, ev_ready;
  logic [3:0]  ev_sid = 0;
  logic [1:0]  ev_tag = 0;
  logic [5:0]  ev_time = 0;
  logic [3:0]  uc_addr, wt_addr, wt_wdata, wt_rdata;
  logic [15:0] uc_data;
  logic        wt_we;
  logic [15:0] cfg_base = {4'd12, 4'd8, 4'd4, 4'd0};
  logic [4:0]  cfg_len = 0;
  logic [31:0] cfg_init = 32'h0000_0300;
  logic        soft_rst = 0, clr_out = 0, flush = 0;
  logic        out_valid, out_ready = 0;
  logic [7:0]  out_data;

  logic [15:0] ucmem [16];
  logic [3:0]  wmem [16];
  int total = 0, bad = 0;
  bit logging = 0;
  int nlog = 0;
  logic [7:0] logv [8];

  always #5 clk = ~clk;

  assign uc_data  = ucmem[uc_addr];
  assign wt_rdata = wmem[wt_addr];
  always @(posedge clk) if (wt_we) wmem[wt_addr] <= wt_wdata;
  always @(negedge clk) if (logging && out_valid && out_ready && nlog < 8) begin
    logv[nlog] = out_data;
    nlog++;
  end

  spk_ucode_neuron i_spk_ucode_neuron (
    .clk, .rst_n, .ev_valid, .ev_ready, .ev_sid, .ev_tag, .ev_time,
    .uc_addr, .uc_data, .wt_addr, .wt_rdata, .wt_we, .wt_wdata,
    .cfg_base, .cfg_len, .cfg_init, .soft_rst, .clr_out, .flush,
    .out_valid, .out_ready, .out_data
  );

  function automatic logic [15:0] uw(input logic [3:0] op, input logic [2:0] rd, rs, input logic [5:0] imm);
    return {op, rd, rs, imm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic [3:0] sid, input logic [1:0] tag, input logic [5:0] ts);
    ev_sid = sid; ev_tag = tag; ev_time = ts; ev_valid = 1;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic pulse_soft();
    soft_rst = 1; @(negedge clk); soft_rst = 0;
  endtask

  task automatic ack();
    out_ready = 1; @(negedge clk); out_ready = 0;
  endtask

  task automatic expect_beat(input string req, input logic [7:0] exp);
    bit got = 0;
    for (int i = 0; i < 30; i++) begin
      if (out_valid) begin got = 1; break; end
      @(negedge clk);
    end
    chk(req, {got, out_data}, {1'b1, exp});
    ack();
  endtask

  task automatic prog(input int base, input logic [15:0] w0, w1, w2, w3);
    ucmem[base] = w0; ucmem[base+1] = w1; ucmem[base+2] = w2; ucmem[base+3] = w3;
  endtask

  task automatic t_reset();
    chk("R2 ready after reset", ev_ready, 1);
    chk("R2 no beat after reset", out_valid, 0);
    chk("R9 no write after reset", wt_we, 0);
  endtask

  task automatic t_fire();
    cfg_len = 3; pulse_soft();
    prog(0, uw(RECV,0,0,0), uw(ADDI,RV,0,6'd4), uw(FIRE,0,0,0), 0);
    push(5, 0, 9);
    tick(1); chk("R2 start at tag0 base", uc_addr, 0);
    tick(1); chk("R3 step", uc_addr, 1);
    tick(1); chk("R3 step", uc_addr, 2);
    chk("R8 no beat before FIRE", out_valid, 0);
    tick(1); chk("R8 beat after FIRE", {out_valid, out_data}, {1'b1, 8'h8B});
    ack();
  endtask

  task automatic t_tag();
    prog(8, uw(RECV,0,0,0), uw(ADDI,RV,0,6'h3F), uw(FIRE,0,0,0), 0);
    push(10, 2, 1);
    tick(1); chk("R2 start at tag2 base", uc_addr, 8);
    expect_beat("R8 no spike beat", 8'hD4);
  endtask

  task automatic t_sat();
    cfg_len = 4; pulse_soft();
    prog(4, uw(RECV,0,0,0), uw(ADDI,RV,0,6'd7), uw(ADDI,RV,0,6'd7), uw(FIRE,0,0,0));
    push(3, 1, 0);
    expect_beat("R5 positive saturation", 8'hA7);
    prog(12, uw(RECV,0,0,0), uw(ADDI,RV,0,6'h38), uw(ADDI,RV,0,6'h38), uw(STDP,RV,RAUX,0));
    push(6, 3, 0);
    tick(8);
    chk("R5 negative saturation", wmem[6], 4'hF);
  endtask

  task automatic t_decay();
    pulse_soft();
    prog(0, uw(ADDI,RV,0,6'd6), uw(LEAK,RV,0,6'd1), uw(FIRE,0,0,6'd2), 0);
    push(0, 0, 0); expect_beat("R7 LEAK then fire", 8'h81);
    prog(4, uw(ADDI,RV,0,6'd3), uw(FIRE,0,0,0), uw(REFR,0,0,0), uw(REFR,0,0,6'd1));
    push(0, 1, 0); expect_beat("R8 refractory blocks", 8'h80);
    prog(8, uw(ADDI,RV,0,6'd1), uw(FIRE,0,0,0), 0, 0);
    push(0, 2, 0); expect_beat("R7 REFR shifts V", 8'h80);
    prog(12, uw(ADDI,RV,0,6'd1), uw(FIRE,0,0,0), 0, 0);
    push(0, 3, 0); expect_beat("R7 REFR counts R down", 8'h81);
    prog(0, uw(ADDI,RT0,0,6'd5), uw(TDEC,RT0,0,6'd1), uw(MOV,RV,RT0,0), uw(FIRE,0,0,0));
    push(0, 0, 0); expect_beat("R7 TDEC step", 8'h81);
    wmem[0] = 4'h1;
    prog(4, uw(TDEC,RT0,0,6'd2), uw(STDP,RT0,RAUX,0), 0, 0);
    push(0, 1, 0); tick(8);
    chk("R7 TDEC floors at 0", wmem[0], 4'h0);
  endtask

  task automatic t_learn();
    pulse_soft();
    prog(0, uw(RECV,0,0,0), uw(ADDI,RW_,0,6'd7), uw(STDP,RW_,RAUX,0), uw(LDW,RI,0,0));
    push(9, 0, 33); tick(8);
    chk("R9 clamp to +1", wmem[9], 4'h1);
    prog(4, uw(ADD,RV,RI,0), uw(ADD,RV,RI,0), uw(ADD,RV,RI,0), uw(FIRE,0,0,0));
    push(1, 1, 0);
    expect_beat("R6 LDW and last fields", 8'h93);
  endtask

  task automatic t_hold();
    pulse_soft();
    prog(0, uw(RECV,0,0,0), uw(FIRE,0,0,0), 0, 0);
    push(2, 0, 0);
    tick(6);
    chk("R10 first beat", {out_valid, out_data}, {1'b1, 8'h84});
    push(7, 0, 0); tick(8);
    chk("R10 held beat kept", {out_valid, out_data}, {1'b1, 8'h84});
    ack();
    chk("R10 ack releases", out_valid, 0);
    push(7, 0, 0); tick(6);
    chk("R10 next beat", {out_valid, out_data}, {1'b1, 8'h8E});
    clr_out = 1; @(negedge clk); clr_out = 0;
    chk("R10 clear drops beat", out_valid, 0);
  endtask

  task automatic t_full();
    int low = 0;
    cfg_len = 8; pulse_soft();
    for (int i = 0; i < 8; i++) ucmem[i] = 0;
    ucmem[0] = uw(RECV,0,0,0); ucmem[7] = uw(FIRE,0,0,0);
    nlog = 0; logging = 1; out_ready = 1;
    push(1, 0, 0); tick(1);
    push(2, 0, 0); push(3, 0, 0);
    chk("R1 ready low when full", ev_ready, 0);
    ev_sid = 4; ev_tag = 0; ev_valid = 1;
    while (!ev_ready && low < 40) begin low++; @(negedge clk); end
    @(negedge clk); ev_valid = 0;
    chk("R1 push waited for dequeue", low > 0, 1);
    tick(40);
    chk("R1 four beats", nlog, 4);
    chk("R1 order", {logv[0][4:1], logv[1][4:1], logv[2][4:1], logv[3][4:1]}, 16'h1234);
    logging = 0; out_ready = 0;
  endtask

  task automatic t_flush();
    nlog = 0; logging = 1; out_ready = 1;
    push(5, 0, 0); tick(1);
    push(6, 0, 0); push(7, 0, 0);
    flush = 1; @(negedge clk); flush = 0;
    tick(40);
    chk("R12 only running event fires", nlog, 1);
    chk("R12 surviving beat", logv[0][4:1], 5);
    logging = 0; out_ready = 0;
  endtask

  task automatic t_soft();
    cfg_len = 4; pulse_soft();
    prog(0, uw(RECV,0,0,0), uw(ADDI,RV,0,6'd5), 0, 0);
    push(5, 0, 0); tick(8);
    pulse_soft();
    prog(4, uw(FIRE,0,0,0), 0, 0, 0);
    push(0, 1, 0);
    expect_beat("R11 reload and clear", 8'h80);
  endtask

  task automatic t_len0();
    cfg_len = 0;
    push(4, 1, 0); tick(8);
    chk("R2 zero length discards", {out_valid, ev_ready}, 2'b01);
    cfg_len = 4;
    prog(0, uw(RECV,0,0,0), 16'hF1C7, 0, uw(FIRE,0,0,0));
    push(4, 0, 0);
    expect_beat("R4 unused opcode is no-op", 8'h88);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin ucmem[i] = 0; wmem[i] = 0; end
    tick(3); rst_n = 1; tick(1);
    t_reset();
    t_fire();
    t_tag();
    t_sat();
    t_decay();
    t_learn();
    t_hold();
    t_full();
    t_flush();
    t_soft();
    t_len0();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20000 * 10);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule